// File: doc/BRIEF.md
# Prioritized Interrupt Level Controller

This block gathers interrupt requests arranged as a set of priority levels, each level owning a 64-bit word of individual source bits. Sources are set and cleared one at a time through a small command port, or all at once with a clear-all command. A summary status word keeps one bit per level, set while that level holds any pending source.

Every cycle, a combinational scan combines the software request register with the external levels of the status word. It produces one priority and a mask of the levels that took part. Software requests are encoded on a compact scale, where the offset above the lowest software level plus one is the priority. External levels use their own level number as their priority, and any pending external level overrides a software priority.

An interrupt is taken only when all of the following hold: the status word is nonzero, the program counter is word aligned, and the priority is nonzero and strictly above the current threshold. When it is taken, the winning priority and mask are captured and held until the core acknowledges. The acknowledge then moves them to the ID and summary outputs.

Top module: `irq_level_ctrl`

## Requirements
- R1: A post command (cmd_op 2'b00 with cmd_valid) to level L, index I sets bit I of level L and sets status bit L at the next clock edge.
- R2: A clear command (cmd_op 2'b01) clears bit I of level L; status bit L falls only when the whole 64-bit word of level L becomes zero.
- R3: A clear-all command (cmd_op 2'b10) zeroes every level word and the status word at the next edge. cmd_op 2'b11 does nothing.
- R4: A post or clear with a level of NUM_LEVELS or more, or an index of 64 or more, changes no state and raises cmd_err for one cycle after the edge.
- R5: irq_pending is high exactly when status is nonzero and pc_low is 2'b00.
- R6: For software levels SW_LO..SW_HI (defaults 1..15), each set sw_req bit i contributes priority i-SW_LO+1 and sets mask bit i; the highest set bit gives the priority.
- R7: For external levels EXT_LO..EXT_HI (defaults 16..30), each set status bit sets its mask bit, and the highest one sets the priority to its level number, overriding any software priority.
- R8: take_irq rises one edge after the following all hold together: irq_pending, ast_req low, priority nonzero, and priority strictly greater than cur_ipl. A priority equal to cur_ipl is not taken.
- R9: Once taken, take_irq stays high and int_id/int_summary stay unchanged until ack. On ack with take_irq high, int_id and int_summary load the captured priority and mask at that edge, and take_irq falls.
- R10: A high ast_req blocks any interrupt from being taken and raises ast_err one cycle later.
- R11: An ack while take_irq is low leaves int_id and int_summary unchanged and raises ack_err for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 post, 01 clear, 10 clear-all, 11 none |
| cmd_level | input | LVL_W+1 | Target level |
| cmd_index | input | IDX_W | Source bit within the level |
| sw_req | input | NUM_LEVELS | Software request register |
| cur_ipl | input | LVL_W | Current priority threshold |
| pc_low | input | 2 | Low two bits of the program counter |
| ast_req | input | 1 | Asynchronous trap request (unsupported) |
| ack | input | 1 | Core acknowledge of a taken interrupt |
| status | output | NUM_LEVELS | Per-level pending summary |
| irq_pending | output | 1 | Pending check result |
| take_irq | output | 1 | Interrupt taken, awaiting acknowledge |
| int_id | output | LVL_W | Priority delivered on acknowledge |
| int_summary | output | NUM_LEVELS | Level mask delivered on acknowledge |
| cmd_err | output | 1 | Out-of-range command flag |
| ack_err | output | 1 | Acknowledge without a taken interrupt |
| ast_err | output | 1 | Asynchronous trap request flag |

## Verification
A corrupted source word shows up in status one edge after the command that should have cleared its level, because the level keeps its status bit when it should not. A fault in the scan surfaces as a wrong int_id or int_summary on the first acknowledge after the cause. A wrong threshold comparison shows up as take_irq rising, or failing to rise, two edges after the level is posted. A lost or stuck capture flag is seen on take_irq within one edge of an acknowledge or of an acknowledge sent with no interrupt taken.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    OP_POST   = 2'b00,
    OP_CLEAR  = 2'b01,
    OP_CLRALL = 2'b10,
    OP_NONE   = 2'b11
  } irq_op_e;
endpackage

// File: rtl/irqc_src_bank.sv
module irqc_src_bank #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int LVL_W      = 5,
  parameter int IDX_W      = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [LVL_W:0]        cmd_level,
  input  logic [IDX_W-1:0]      cmd_index,
  output logic [NUM_LEVELS-1:0] status,
  output logic                  cmd_err
);
  import irqc_pkg::*;

  irq_op_e          op;
  logic             in_range;
  logic             is_post;
  logic             is_clear;
  logic             is_clrall;
  logic [SRC_W-1:0] bit_sel;
  logic             err_n;
  logic             err_q;

  assign op        = irq_op_e'(cmd_op);
  assign in_range  = (cmd_level < (LVL_W+1)'(NUM_LEVELS)) && (cmd_index < IDX_W'(SRC_W));
  assign is_post   = cmd_valid && (op == OP_POST);
  assign is_clear  = cmd_valid && (op == OP_CLEAR);
  assign is_clrall = cmd_valid && (op == OP_CLRALL);
  assign bit_sel   = SRC_W'(1) << cmd_index[IDX_W-2:0];
  assign err_n     = (is_post || is_clear) && !in_range;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_lvl
    logic [SRC_W-1:0] word_q;
    logic [SRC_W-1:0] word_n;
    logic             hit;
    logic             en;
    logic             st_q;

    assign hit = in_range && (cmd_level == (LVL_W+1)'(g));
    assign en  = is_clrall || (hit && (is_post || is_clear));

    always_comb begin
      word_n = word_q;
      if (is_clrall)            word_n = '0;
      else if (hit && is_post)  word_n = word_q | bit_sel;
      else if (hit && is_clear) word_n = word_q & ~bit_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
        st_q   <= 1'b0;
      end else if (en) begin
        word_q <= word_n;
        st_q   <= |word_n;
      end
    end

    assign status[g] = st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_n;
  end

  assign cmd_err = err_q;
endmodule

// File: rtl/irqc_prio_scan.sv
module irqc_prio_scan #(
  parameter int NUM_LEVELS = 32,
  parameter int LVL_W      = 5,
  parameter int SW_LO      = 1,
  parameter int SW_HI      = 15,
  parameter int EXT_LO     = 16,
  parameter int EXT_HI     = 30
) (
  input  logic [NUM_LEVELS-1:0] status,
  input  logic [NUM_LEVELS-1:0] sw_req,
  output logic [LVL_W-1:0]      prio,
  output logic [NUM_LEVELS-1:0] mask
);
  always_comb begin
    prio = '0;
    mask = '0;
    for (int i = SW_LO; i <= SW_HI; i++) begin
      if (sw_req[i]) begin
        prio    = LVL_W'(i - SW_LO + 1);
        mask[i] = 1'b1;
      end
    end
    for (int i = EXT_LO; i <= EXT_HI; i++) begin
      if (status[i]) begin
        prio    = LVL_W'(i);
        mask[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl #(
  parameter int NUM_LEVELS = 32,
  parameter int SRC_W      = 64,
  parameter int SW_LO      = 1,
  parameter int SW_HI      = 15,
  parameter int EXT_LO     = 16,
  parameter int EXT_HI     = 30,
  localparam int LVL_W     = $clog2(NUM_LEVELS),
  localparam int IDX_W     = $clog2(SRC_W) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [1:0]            cmd_op,
  input  logic [LVL_W:0]        cmd_level,
  input  logic [IDX_W-1:0]      cmd_index,
  input  logic [NUM_LEVELS-1:0] sw_req,
  input  logic [LVL_W-1:0]      cur_ipl,
  input  logic [1:0]            pc_low,
  input  logic                  ast_req,
  input  logic                  ack,
  output logic [NUM_LEVELS-1:0] status,
  output logic                  irq_pending,
  output logic                  take_irq,
  output logic [LVL_W-1:0]      int_id,
  output logic [NUM_LEVELS-1:0] int_summary,
  output logic                  cmd_err,
  output logic                  ack_err,
  output logic                  ast_err
);
  logic [LVL_W-1:0]      prio;
  logic [NUM_LEVELS-1:0] mask;
  logic                  fire;

  logic                  cap_v_q,   cap_v_n;
  logic [LVL_W-1:0]      cap_ipl_q, cap_ipl_n;
  logic [NUM_LEVELS-1:0] cap_sum_q, cap_sum_n;
  logic [LVL_W-1:0]      id_q,      id_n;
  logic [NUM_LEVELS-1:0] sum_q,     sum_n;
  logic                  aerr_q,    aerr_n;
  logic                  terr_q;

  irqc_src_bank #(
    .NUM_LEVELS(NUM_LEVELS), .SRC_W(SRC_W), .LVL_W(LVL_W), .IDX_W(IDX_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_level(cmd_level), .cmd_index(cmd_index),
    .status(status), .cmd_err(cmd_err)
  );

  irqc_prio_scan #(
    .NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
    .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)
  ) u_scan (
    .status(status), .sw_req(sw_req), .prio(prio), .mask(mask)
  );

  assign irq_pending = (|status) && (pc_low == 2'b00);
  assign fire        = irq_pending && !ast_req && (prio != '0) && (prio > cur_ipl);

  always_comb begin
    cap_v_n   = cap_v_q;
    cap_ipl_n = cap_ipl_q;
    cap_sum_n = cap_sum_q;
    id_n      = id_q;
    sum_n     = sum_q;
    aerr_n    = 1'b0;
    if (ack) begin
      if (cap_v_q) begin
        id_n    = cap_ipl_q;
        sum_n   = cap_sum_q;
        cap_v_n = 1'b0;
      end else begin
        aerr_n  = 1'b1;
      end
    end else if (!cap_v_q && fire) begin
      cap_v_n   = 1'b1;
      cap_ipl_n = prio;
      cap_sum_n = mask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_v_q   <= 1'b0;
      cap_ipl_q <= '0;
      cap_sum_q <= '0;
      id_q      <= '0;
      sum_q     <= '0;
      aerr_q    <= 1'b0;
      terr_q    <= 1'b0;
    end else begin
      cap_v_q   <= cap_v_n;
      cap_ipl_q <= cap_ipl_n;
      cap_sum_q <= cap_sum_n;
      id_q      <= id_n;
      sum_q     <= sum_n;
      aerr_q    <= aerr_n;
      terr_q    <= ast_req;
    end
  end

  assign take_irq    = cap_v_q;
  assign int_id      = id_q;
  assign int_summary = sum_q;
  assign ack_err     = aerr_q;
  assign ast_err     = terr_q;
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
  parameter int NUM_LEVELS = 32,
  localparam int LVL_W     = $clog2(NUM_LEVELS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic [1:0]            cmd_op,
  input logic [NUM_LEVELS-1:0] status,
  input logic                  take_irq,
  input logic                  ack,
  input logic                  ack_err,
  input logic [LVL_W-1:0]      int_id,
  input logic [NUM_LEVELS-1:0] int_summary,
  input logic                  cmd_err,
  input logic                  ast_req,
  input logic [1:0]            pc_low
);
  assert_bad_cmd_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> $stable(status));

  assert_clear_all_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 2'b10) |=> (status == '0));

  assert_take_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_irq) |-> $past(pc_low == 2'b00 && status != '0 && !ast_req));

  assert_hold_until_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && !ack) |=> (take_irq && $stable(int_id) && $stable(int_summary)));

  assert_ack_drops_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && ack) |=> !take_irq);

  assert_stray_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !take_irq) |=> (ack_err && $stable(int_id) && $stable(int_summary)));

  assert_trap_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ast_req && !take_irq) |=> !take_irq);
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (.*);

// File: tb/irq_level_ctrl_tb.sv
module irq_level_ctrl_tb;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [5:0]    cmd_level;
  logic [6:0]    cmd_index;
  logic [NL-1:0] sw_req;
  logic [4:0]    cur_ipl;
  logic [1:0]    pc_low;
  logic          ast_req;
  logic          ack;
  logic [NL-1:0] status;
  logic          irq_pending;
  logic          take_irq;
  logic [4:0]    int_id;
  logic [NL-1:0] int_summary;
  logic          cmd_err;
  logic          ack_err;
  logic          ast_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  irq_level_ctrl u_dut (.*);

  always #10 clk = ~clk;

  // op, level, index, expected status, expected cmd_err
  localparam logic [47:0] VEC [12] = '{
    {2'b00, 6'd20, 7'd5,  32'h0010_0000, 1'b0},   // R1
    {2'b00, 6'd20, 7'd63, 32'h0010_0000, 1'b0},   // R1
    {2'b01, 6'd20, 7'd5,  32'h0010_0000, 1'b0},   // R2 level not empty
    {2'b01, 6'd20, 7'd63, 32'h0000_0000, 1'b0},   // R2 level empty
    {2'b00, 6'd40, 7'd3,  32'h0000_0000, 1'b1},   // R4 level range
    {2'b00, 6'd3,  7'd64, 32'h0000_0000, 1'b1},   // R4 index range
    {2'b00, 6'd3,  7'd0,  32'h0000_0008, 1'b0},   // R1
    {2'b00, 6'd17, 7'd1,  32'h0002_0008, 1'b0},   // R1
    {2'b01, 6'd17, 7'd2,  32'h0002_0008, 1'b0},   // R2 clear of idle bit
    {2'b11, 6'd17, 7'd1,  32'h0002_0008, 1'b0},   // R3 no-op code
    {2'b10, 6'd0,  7'd0,  32'h0000_0000, 1'b0},   // R3
    {2'b01, 6'd31, 7'd64, 32'h0000_0000, 1'b1}    // R4 clear out of range
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [1:0] op, input logic [5:0] lvl, input logic [6:0] idx);
    cmd_op = op; cmd_level = lvl; cmd_index = idx; cmd_valid = 1'b1;
    cyc(1);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b11; cmd_level = '0; cmd_index = '0;
    sw_req = '0; cur_ipl = 5'd31; pc_low = 2'b00; ast_req = 1'b0; ack = 1'b0;
    cyc(3);
    chk("R1 reset status", 64'(status), 64'h0);
    chk("R9 reset take", 64'(take_irq), 64'h0);
    chk("R9 reset id", 64'(int_id), 64'h0);
    chk("R11 reset errs", 64'({cmd_err, ack_err, ast_err}), 64'h0);
    rst_n = 1'b1;
    cyc(1);

    for (int v = 0; v < 12; v++) begin
      send(VEC[v][47:46], VEC[v][45:40], VEC[v][39:33]);
      chk("R1/R2/R3 table status", 64'(status), 64'(VEC[v][32:1]));
      chk("R4 table cmd_err", 64'(cmd_err), 64'(VEC[v][0]));
      chk("R8 table no take", 64'(take_irq), 64'h0);
    end

    // R7: external level 18 overrides software bits 2 and 5
    sw_req = 32'h0000_0024; cur_ipl = 5'd10;
    send(2'b00, 6'd18, 7'd0);
    cyc(1);
    chk("R8 take after external post", 64'(take_irq), 64'h1);
    chk("R9 id held before ack", 64'(int_id), 64'h0);
    ack = 1'b1; cur_ipl = 5'd31;
    cyc(1);
    ack = 1'b0;
    chk("R7 external id", 64'(int_id), 64'd18);
    chk("R7 mask", 64'(int_summary), 64'h0004_0024);
    chk("R9 take drops", 64'(take_irq), 64'h0);
    send(2'b10, 6'd0, 7'd0);
    chk("R3 clear-all", 64'(status), 64'h0);

    // R6: software only, status nonzero through level 3
    sw_req = 32'h0000_0210; cur_ipl = 5'd9;
    send(2'b00, 6'd3, 7'd0);
    chk("R5 pending aligned", 64'(irq_pending), 64'h1);
    cyc(3);
    chk("R8 equal threshold not taken", 64'(take_irq), 64'h0);
    cur_ipl = 5'd8;
    cyc(1);
    chk("R8 take above threshold", 64'(take_irq), 64'h1);
    ack = 1'b1; cur_ipl = 5'd31;
    cyc(1);
    ack = 1'b0;
    chk("R6 software id", 64'(int_id), 64'd9);
    chk("R6 software mask", 64'(int_summary), 64'h0000_0210);

    // R5: misaligned program counter
    pc_low = 2'b01; cur_ipl = 5'd0;
    cyc(1);
    chk("R5 pending misaligned", 64'(irq_pending), 64'h0);
    cyc(2);
    chk("R5 no take misaligned", 64'(take_irq), 64'h0);
    pc_low = 2'b00; cur_ipl = 5'd31;

    // R10: trap request
    ast_req = 1'b1; cur_ipl = 5'd0;
    cyc(1);
    chk("R10 ast_err", 64'(ast_err), 64'h1);
    chk("R10 no take", 64'(take_irq), 64'h0);
    ast_req = 1'b0; cur_ipl = 5'd31;
    cyc(1);
    chk("R10 ast_err drops", 64'(ast_err), 64'h0);

    // R11: stray acknowledge
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    chk("R11 ack_err", 64'(ack_err), 64'h1);
    chk("R11 id unchanged", 64'(int_id), 64'd9);
    chk("R11 mask unchanged", 64'(int_summary), 64'h0000_0210);

    // R8: zero priority (only level 3 pending, no software bits)
    sw_req = '0; cur_ipl = 5'd0;
    cyc(3);
    chk("R8 zero priority not taken", 64'(take_irq), 64'h0);

    // R5: software request with empty status word
    send(2'b10, 6'd0, 7'd0);
    sw_req = 32'h0000_8000;
    cyc(3);
    chk("R5 empty status not pending", 64'(irq_pending), 64'h0);
    chk("R8 empty status no take", 64'(take_irq), 64'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule